// File: doc/BRIEF.md
# Byte-Banked Word Memory Access Splitter

This block connects a 16-bit requester to a byte-addressed memory that is built from two byte-wide banks. One bank holds the bytes at even addresses and the other holds the bytes at odd addresses. Address bit 0 selects the bank, and the upper address bits select the row inside a bank. The requester presents a byte or word access with a 20-bit byte address. The block turns it into one or two bank cycles, drives the per-bank enables and write strobes, and steers bytes between the requester and the fixed bank lanes. It signals completion with a single-cycle done pulse.

The request side uses a valid/ready handshake. An access is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from that edge until the access has finished. While it is low, the requester must hold its request, and the block does not look at the request inputs. There is no back-pressure on the response: the requester must capture `rsp_rdata` in the cycle where `rsp_done` is high.

The banks are modelled as combinational-read storage. In a bank cycle, the data a bank returns on `mem_rdata` is used in that same cycle. Writes take effect at the clock edge that closes the bank cycle. On the requester side, data is right-justified: a byte travels in bits [7:0], and for a word the byte at the lower address travels in bits [7:0]. On the bank side, lane [7:0] always belongs to the even bank and lane [15:8] always belongs to the odd bank.

Top module: `bytebank_splitter`

## Requirements
- R1: `req_ready` is high exactly when the block is idle. An access is accepted on an edge with `req_valid` and `req_ready` both high, and its first bank cycle runs in the clock cycle that follows. Request inputs presented while `req_ready` is low cause no bank activity. `req_ready` is high again in the cycle after the done pulse.
- R2: After synchronous reset, `req_ready` is high, and `rsp_done`, both bank enables and both write strobes are low.
- R3: A byte access at an even address runs one bank cycle. In that cycle only `mem_en_even` is high and `mem_row` equals address bits [19:1]. A read returns {8'h00, `mem_rdata[7:0]`}.
- R4: A byte access at an odd address runs one bank cycle. In that cycle only `mem_en_odd` is high and `mem_row` equals address bits [19:1]. A read returns {8'h00, `mem_rdata[15:8]`}.
- R5: A word access at an even address enables both banks in one cycle, with `mem_row` equal to address bits [19:1]. A read returns `mem_rdata` unchanged.
- R6: A word access at an odd address runs two cycles. The first cycle enables only the odd bank, at row address[19:1]. The second cycle enables only the even bank, at that row plus one. The read result is {even-bank byte from the second cycle, odd-bank byte from the first cycle}.
- R7: A word access at 0xFFFFF uses row 0x7FFFF in its first cycle and wraps to row 0x00000 in its second cycle.
- R8: On writes, the requester's low byte goes to the lane of the bank holding the lower address, and the high byte goes to the other bank's lane. A strobe is high only for a bank that is enabled in that cycle. A lane not being written carries zero.
- R9: `rsp_done` is high for exactly one cycle, which is the final bank cycle of the access. `rsp_rdata` is zero whenever `rsp_done` is low and for every write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_addr | input | 20 | Byte address |
| req_word | input | 1 | 1 = word, 0 = byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data, right-justified |
| rsp_done | output | 1 | Completion pulse in the final bank cycle |
| rsp_rdata | output | 16 | Read result, valid while done is high |
| mem_row | output | 19 | Row address shared by both banks |
| mem_en_even | output | 1 | Even bank enable |
| mem_en_odd | output | 1 | Odd bank enable |
| mem_we_even | output | 1 | Even bank write strobe |
| mem_we_odd | output | 1 | Odd bank write strobe |
| mem_wdata | output | 16 | Bank write lanes: [7:0] even, [15:8] odd |
| mem_rdata | input | 16 | Bank read lanes: [7:0] even, [15:8] odd |

## Verification
Several rules are checked by assertions on every clock cycle. These cover the handshake ordering, the quiet bank outputs while idle, strobes staying inside enables, the single-cycle done pulse, a zero read bus outside done, and the shape of a split access (odd-only followed by even-only at the next row, including the wrap). Other behaviour can only be shown by the directed scenarios, because it depends on the data and the address that were requested. This includes which requester byte lands in which bank lane, how the bytes of a split read are reassembled, and the row chosen for each size and alignment. The scenarios also show that a request offered while the block is busy leaves no trace on the bank outputs.

// File: rtl/bbs_pkg.sv
`timescale 1ns/1ps
package bbs_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_FIRST  = 2'd1,
    SEQ_SECOND = 2'd2
  } seq_state_t;

  localparam int LANE_EVEN = 0;
  localparam int LANE_ODD  = 1;
  localparam int NUM_LANES = 2;
endpackage

// File: rtl/bbs_sequencer.sv
`timescale 1ns/1ps
module bbs_sequencer
  import bbs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int LANE_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic                 req_word,
  input  logic                 req_write,
  input  logic [2*LANE_W-1:0]  req_wdata,
  output logic                 st_first,
  output logic                 st_second,
  output logic                 split,
  output logic                 done,
  output logic                 addr_lsb,
  output logic                 word_q,
  output logic                 write_q,
  output logic [2*LANE_W-1:0]  wdata_q,
  output logic [ADDR_W-2:0]    row
);
  localparam int ROW_W = ADDR_W - 1;
  localparam int BUS_W = 2 * LANE_W;

  seq_state_t        state_q;
  seq_state_t        state_d;
  logic [ADDR_W-1:0] addr_q;
  logic              accept;
  logic [ROW_W-1:0]  row_base;
  logic [ROW_W-1:0]  row_next;

  assign req_ready = (state_q == SEQ_IDLE);
  assign accept    = req_valid && req_ready;
  assign st_first  = (state_q == SEQ_FIRST);
  assign st_second = (state_q == SEQ_SECOND);
  assign addr_lsb  = addr_q[0];
  assign split     = word_q && addr_q[0];
  assign done      = (st_first && !split) || st_second;

  // the second half of a split word always lives one row further on
  assign row_base  = addr_q[ADDR_W-1:1];
  assign row_next  = row_base + ROW_W'(1);
  assign row       = st_second ? row_next : row_base;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE:   if (accept) state_d = SEQ_FIRST;
      SEQ_FIRST:  state_d = split ? SEQ_SECOND : SEQ_IDLE;
      SEQ_SECOND: state_d = SEQ_IDLE;
      default:    state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      addr_q  <= '0;
      word_q  <= 1'b0;
      write_q <= 1'b0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        addr_q  <= req_addr;
        word_q  <= req_word;
        write_q <= req_write;
        wdata_q <= req_wdata;
      end
    end
  end

  logic unused_ok;
  assign unused_ok = ^{BUS_W};
endmodule

// File: rtl/bbs_lane_steer.sv
`timescale 1ns/1ps
module bbs_lane_steer
  import bbs_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic                 st_first,
  input  logic                 st_second,
  input  logic                 addr_lsb,
  input  logic                 word_q,
  input  logic                 write_q,
  input  logic [2*LANE_W-1:0]  wdata_q,
  output logic                 en_even,
  output logic                 en_odd,
  output logic                 we_even,
  output logic                 we_odd,
  output logic [2*LANE_W-1:0]  mem_wdata
);
  localparam int BUS_W = 2 * LANE_W;

  logic [NUM_LANES-1:0] lane_en;
  logic [LANE_W-1:0]    lane_src [NUM_LANES];
  logic [LANE_W-1:0]    byte_lo;
  logic [LANE_W-1:0]    byte_hi;

  assign byte_lo = wdata_q[LANE_W-1:0];
  assign byte_hi = wdata_q[BUS_W-1:LANE_W];

  // even lane: first cycle of an even access, or the tail of a split word
  assign lane_en[LANE_EVEN]  = (st_first && !addr_lsb) || st_second;
  // odd lane: first cycle of an odd access, or any word access
  assign lane_en[LANE_ODD]   = st_first && (addr_lsb || word_q);

  // even lane carries the high byte only in the tail of a split word
  assign lane_src[LANE_EVEN] = st_second ? byte_hi : byte_lo;
  // odd lane carries the low byte when the access starts on it
  assign lane_src[LANE_ODD]  = addr_lsb ? byte_lo : byte_hi;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    assign mem_wdata[l*LANE_W +: LANE_W] =
      (lane_en[l] && write_q) ? lane_src[l] : '0;
  end

  assign en_even = lane_en[LANE_EVEN];
  assign en_odd  = lane_en[LANE_ODD];
  assign we_even = lane_en[LANE_EVEN] && write_q;
  assign we_odd  = lane_en[LANE_ODD]  && write_q;
endmodule

// File: rtl/bbs_read_merge.sv
`timescale 1ns/1ps
module bbs_read_merge #(
  parameter int LANE_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 st_first,
  input  logic                 st_second,
  input  logic                 split,
  input  logic                 done,
  input  logic                 addr_lsb,
  input  logic                 word_q,
  input  logic                 write_q,
  input  logic [2*LANE_W-1:0]  mem_rdata,
  output logic [2*LANE_W-1:0]  rsp_rdata
);
  localparam int BUS_W = 2 * LANE_W;

  logic [LANE_W-1:0] hold_q;
  logic [LANE_W-1:0] lane_even;
  logic [LANE_W-1:0] lane_odd;

  assign lane_even = mem_rdata[LANE_W-1:0];
  assign lane_odd  = mem_rdata[BUS_W-1:LANE_W];

  // keep the low byte of a split word across to the second cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
    end else if (st_first && split) begin
      hold_q <= lane_odd;
    end
  end

  always_comb begin
    rsp_rdata = '0;
    if (done && !write_q) begin
      if (st_second) begin
        rsp_rdata = {lane_even, hold_q};
      end else if (word_q) begin
        rsp_rdata = mem_rdata;
      end else if (addr_lsb) begin
        rsp_rdata = {{LANE_W{1'b0}}, lane_odd};
      end else begin
        rsp_rdata = {{LANE_W{1'b0}}, lane_even};
      end
    end
  end
endmodule

// File: rtl/bytebank_splitter.sv
`timescale 1ns/1ps
module bytebank_splitter #(
  parameter int ADDR_W = 20,
  parameter int LANE_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic                 req_word,
  input  logic                 req_write,
  input  logic [2*LANE_W-1:0]  req_wdata,
  output logic                 rsp_done,
  output logic [2*LANE_W-1:0]  rsp_rdata,
  output logic [ADDR_W-2:0]    mem_row,
  output logic                 mem_en_even,
  output logic                 mem_en_odd,
  output logic                 mem_we_even,
  output logic                 mem_we_odd,
  output logic [2*LANE_W-1:0]  mem_wdata,
  input  logic [2*LANE_W-1:0]  mem_rdata
);
  localparam int BUS_W = 2 * LANE_W;

  logic             st_first;
  logic             st_second;
  logic             split;
  logic             addr_lsb;
  logic             word_q;
  logic             write_q;
  logic [BUS_W-1:0] wdata_q;

  bbs_sequencer #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_word  (req_word),
    .req_write (req_write),
    .req_wdata (req_wdata),
    .st_first  (st_first),
    .st_second (st_second),
    .split     (split),
    .done      (rsp_done),
    .addr_lsb  (addr_lsb),
    .word_q    (word_q),
    .write_q   (write_q),
    .wdata_q   (wdata_q),
    .row       (mem_row)
  );

  bbs_lane_steer #(.LANE_W(LANE_W)) u_steer (
    .st_first  (st_first),
    .st_second (st_second),
    .addr_lsb  (addr_lsb),
    .word_q    (word_q),
    .write_q   (write_q),
    .wdata_q   (wdata_q),
    .en_even   (mem_en_even),
    .en_odd    (mem_en_odd),
    .we_even   (mem_we_even),
    .we_odd    (mem_we_odd),
    .mem_wdata (mem_wdata)
  );

  bbs_read_merge #(.LANE_W(LANE_W)) u_merge (
    .clk       (clk),
    .rst       (rst),
    .st_first  (st_first),
    .st_second (st_second),
    .split     (split),
    .done      (rsp_done),
    .addr_lsb  (addr_lsb),
    .word_q    (word_q),
    .write_q   (write_q),
    .mem_rdata (mem_rdata),
    .rsp_rdata (rsp_rdata)
  );
endmodule

// File: rtl/bbs_checker.sv
`timescale 1ns/1ps
module bbs_checker #(
  parameter int ADDR_W = 20,
  parameter int LANE_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                req_valid,
  input logic                req_ready,
  input logic                rsp_done,
  input logic [2*LANE_W-1:0] rsp_rdata,
  input logic [ADDR_W-2:0]   mem_row,
  input logic                mem_en_even,
  input logic                mem_en_odd,
  input logic                mem_we_even,
  input logic                mem_we_odd
);
  localparam int ROW_W = ADDR_W - 1;

  AST_ACCEPT_STARTS_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (!req_ready && (mem_en_even || mem_en_odd))); // R1

  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> req_ready); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!mem_en_even && !mem_en_odd && !rsp_done)); // R2

  AST_SPLIT_TAIL: assert property (@(posedge clk) disable iff (rst)
    (mem_en_odd && !mem_en_even && !rsp_done) |=> (mem_en_even && !mem_en_odd && rsp_done)); // R6

  AST_SPLIT_ROW_STEP: assert property (@(posedge clk) disable iff (rst)
    (mem_en_odd && !mem_en_even && !rsp_done) |=> (mem_row == ROW_W'($past(mem_row) + ROW_W'(1)))); // R7

  AST_STROBE_EVEN_GATED: assert property (@(posedge clk) disable iff (rst)
    mem_we_even |-> mem_en_even); // R8

  AST_STROBE_ODD_GATED: assert property (@(posedge clk) disable iff (rst)
    mem_we_odd |-> mem_en_odd); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done); // R9

  AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (rst)
    !rsp_done |-> (rsp_rdata == '0)); // R9
endmodule

bind bytebank_splitter bbs_checker #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_bbs_checker (.*);

// File: tb/test_bytebank_splitter.sv
`timescale 1ns/1ps
module test_bytebank_splitter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [19:0] req_addr = '0;
  logic        req_word = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_wdata = '0;
  logic        rsp_done;
  logic [15:0] rsp_rdata;
  logic [18:0] mem_row;
  logic        mem_en_even, mem_en_odd, mem_we_even, mem_we_odd;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [7:0] ev_m [256];
  logic [7:0] od_m [256];

  always #2.5 clk = ~clk;

  bytebank_splitter i_bytebank_splitter (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_word(req_word), .req_write(req_write),
    .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .mem_row(mem_row), .mem_en_even(mem_en_even), .mem_en_odd(mem_en_odd),
    .mem_we_even(mem_we_even), .mem_we_odd(mem_we_odd),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // two byte-wide banks, combinational read, 256 rows each
  assign mem_rdata = {od_m[mem_row[7:0]], ev_m[mem_row[7:0]]};
  always @(posedge clk) begin
    if (mem_we_even) ev_m[mem_row[7:0]] <= mem_wdata[7:0];
    if (mem_we_odd)  od_m[mem_row[7:0]] <= mem_wdata[15:8];
  end

  function automatic logic [7:0] f_ev(input int r);
    return 8'(r * 3 + 1);
  endfunction
  function automatic logic [7:0] f_od(input int r);
    return 8'(r) ^ 8'h5A;
  endfunction

  typedef struct packed {
    logic        ready;
    logic        done;
    logic        en_e;
    logic        en_o;
    logic        we_e;
    logic        we_o;
    logic [18:0] row;
    logic [15:0] wdata;
    logic [15:0] rdata;
  } snap_t;

  function automatic snap_t take();
    snap_t s;
    s.ready = req_ready;  s.done = rsp_done;
    s.en_e  = mem_en_even; s.en_o = mem_en_odd;
    s.we_e  = mem_we_even; s.we_o = mem_we_odd;
    s.row   = mem_row;    s.wdata = mem_wdata;  s.rdata = rsp_rdata;
    return s;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drives one request; poke offers a second request while busy
  task automatic run(input logic [19:0] a, input logic w, input logic wr,
                     input logic [15:0] d, input bit poke,
                     output snap_t s1, output snap_t s2, output snap_t s3,
                     output int ncyc);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_word = w; req_write = wr; req_wdata = d;
    @(negedge clk);
    if (poke) begin
      req_addr = 20'h00002; req_word = 1'b1; req_write = 1'b1; req_wdata = 16'hDEAD;
    end else begin
      req_valid = 1'b0;
    end
    s1 = take();
    ncyc = 1;
    s2 = s1;
    if (!s1.done) begin
      @(negedge clk);
      req_valid = 1'b0;
      s2 = take();
      ncyc = 2;
    end
    @(negedge clk);
    s3 = take();
  endtask

  task automatic t_reset();
    snap_t s;
    s = take();
    chk("R2 ready", 32'(s.ready), 1);
    chk("R2 done", 32'(s.done), 0);
    chk("R2 enables", 32'({s.en_e, s.en_o}), 0);
    chk("R2 strobes", 32'({s.we_e, s.we_o}), 0);
  endtask

  task automatic t_even_byte();
    snap_t s1, s2, s3; int n;
    run(20'h00124, 1'b0, 1'b0, 16'h0, 1'b0, s1, s2, s3, n);
    chk("R3 cycles", 32'(n), 1);
    chk("R3 enables", 32'({s1.en_e, s1.en_o}), 32'b10);
    chk("R3 row", 32'(s1.row), 32'h00092);
    chk("R3 rdata", 32'(s1.rdata), 32'({8'h00, f_ev(8'h92)}));
    chk("R9 done", 32'(s1.done), 1);
    chk("R1 ready after", 32'({s3.ready, s3.done}), 32'b10);
  endtask

  task automatic t_odd_byte();
    snap_t s1, s2, s3; int n;
    run(20'h00247, 1'b0, 1'b0, 16'h0, 1'b0, s1, s2, s3, n);
    chk("R4 cycles", 32'(n), 1);
    chk("R4 enables", 32'({s1.en_e, s1.en_o}), 32'b01);
    chk("R4 row", 32'(s1.row), 32'h00123);
    chk("R4 rdata", 32'(s1.rdata), 32'({8'h00, f_od(8'h23)}));
  endtask

  task automatic t_word_aligned();
    snap_t s1, s2, s3; int n;
    run(20'h00310, 1'b1, 1'b0, 16'h0, 1'b0, s1, s2, s3, n);
    chk("R5 cycles", 32'(n), 1);
    chk("R5 enables", 32'({s1.en_e, s1.en_o}), 32'b11);
    chk("R5 row", 32'(s1.row), 32'h00188);
    chk("R5 rdata", 32'(s1.rdata), 32'({f_od(8'h88), f_ev(8'h88)}));
  endtask

  task automatic t_word_split();
    snap_t s1, s2, s3; int n;
    run(20'h00435, 1'b1, 1'b0, 16'h0, 1'b1, s1, s2, s3, n);
    chk("R6 cycles", 32'(n), 2);
    chk("R6 first enables", 32'({s1.en_e, s1.en_o, s1.done}), 32'b010);
    chk("R6 first row", 32'(s1.row), 32'h0021A);
    chk("R9 rdata before done", 32'(s1.rdata), 0);
    chk("R6 second enables", 32'({s2.en_e, s2.en_o, s2.done}), 32'b101);
    chk("R6 second row", 32'(s2.row), 32'h0021B);
    chk("R6 rdata", 32'(s2.rdata), 32'({f_ev(8'h1B), f_od(8'h1A)}));
    chk("R1 busy request ignored", 32'({s3.en_e, s3.en_o, s3.we_e, s3.we_o, s3.ready}), 32'b00001);
    chk("R1 no write from ignored", 32'(ev_m[1]), 32'(f_ev(1)));
  endtask

  task automatic t_wrap();
    snap_t s1, s2, s3; int n;
    run(20'hFFFFF, 1'b1, 1'b0, 16'h0, 1'b0, s1, s2, s3, n);
    chk("R7 first row", 32'(s1.row), 32'h7FFFF);
    chk("R7 second row", 32'(s2.row), 32'h00000);
    chk("R7 rdata", 32'(s2.rdata), 32'({f_ev(0), f_od(8'hFF)}));
  endtask

  task automatic t_writes();
    snap_t s1, s2, s3; int n;
    run(20'h000A1, 1'b1, 1'b1, 16'hBEEF, 1'b0, s1, s2, s3, n);
    chk("R8 split first strobes", 32'({s1.we_e, s1.we_o}), 32'b01);
    chk("R8 split first lanes", 32'(s1.wdata), 32'h0000EF00);
    chk("R8 split second strobes", 32'({s2.we_e, s2.we_o}), 32'b10);
    chk("R8 split second lanes", 32'(s2.wdata), 32'h000000BE);
    chk("R9 write rdata zero", 32'({s2.done, s2.rdata}), 32'h00010000);
    run(20'h000A1, 1'b1, 1'b0, 16'h0, 1'b0, s1, s2, s3, n);
    chk("R8 split readback", 32'(s2.rdata), 32'h0000BEEF);

    run(20'h00040, 1'b0, 1'b1, 16'hAA33, 1'b0, s1, s2, s3, n);
    chk("R8 even byte lanes", 32'({s1.we_e, s1.we_o, s1.wdata}), 32'h00020033);
    run(20'h00043, 1'b0, 1'b1, 16'hAA77, 1'b0, s1, s2, s3, n);
    chk("R8 odd byte lanes", 32'({s1.we_e, s1.we_o, s1.wdata}), 32'h00017700);

    run(20'h00060, 1'b1, 1'b1, 16'h1234, 1'b0, s1, s2, s3, n);
    chk("R8 aligned word lanes", 32'({s1.we_e, s1.we_o, s1.wdata}), 32'h00031234);
    run(20'h00061, 1'b0, 1'b0, 16'h0, 1'b0, s1, s2, s3, n);
    chk("R4 odd byte readback", 32'(s1.rdata), 32'h00000012);
    run(20'h00040, 1'b0, 1'b0, 16'h0, 1'b0, s1, s2, s3, n);
    chk("R3 even byte readback", 32'(s1.rdata), 32'h00000033);
    chk("R8 neighbour untouched", 32'(od_m[8'h20]), 32'(f_od(8'h20)));
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      ev_m[i] = f_ev(i);
      od_m[i] = f_od(i);
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_even_byte();
    t_odd_byte();
    t_word_aligned();
    t_word_split();
    t_wrap();
    t_writes();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule